// File: doc/BRIEF.md
# Register-Mapped SPI Host Front End

This block is the software-facing half of an SPI host. A processor talks to it with 32-bit word reads and writes on a simple select/write bus. Bytes written to the transmit data word are queued in a byte FIFO. While transfers are allowed, a sequencer takes those bytes one at a time and offers each to a separate byte-exchange serial engine. Each byte that the engine returns is stored in a receive FIFO, which software drains by reading the receive data word. The bit-level SPI clocking lives in that serial engine, and interrupt aggregation lives in another block. This front end only raises single-cycle event pulses for a transmit overflow and a receive overrun.

A control word holds a transfer-inhibit flag, which is set out of reset, and two self-clearing flush bits, one for each FIFO. A slave-select word drives the active-low chip-select pins directly. Status and occupancy words report the state of both FIFOs. A key-protected software reset returns the whole block to its reset state. Only byte addresses that match a register exactly are decoded, so a misaligned access reaches no register.

Top module: `spi_host_regs`

## Requirements
- R1: After reset, the control word reads 0x00000100, the slave-select word reads all ones over its NUM_CS bits, the status word reads 0x00000005, both occupancy words read 0, and every chip-select pin is high.
- R2: A write of exactly 0x0000000A to address 0x40 restores the R1 state and empties both FIFOs. A write of any other value to 0x40 changes nothing.
- R3: The status word at 0x64 carries transmit full in bit 3, transmit empty in bit 2, receive full in bit 1 and receive empty in bit 0. All other bits read 0, and writes to it have no effect.
- R4: A control write (0x60) with bit 5 set empties the transmit FIFO, and one with bit 6 set empties the receive FIFO. Bits 5 and 6 always read back as 0, and the other written bits are kept.
- R5: While control bit 8 is 1, eng_tx_valid stays low. Once bit 8 is cleared, queued bytes are offered in order until the transmit FIFO is empty.
- R6: Only bits 7:0 of a write to 0x68 are queued. Every byte the engine returns with eng_rx_done is appended to the receive FIFO, and reads of 0x6C return those bytes in order, each in bits 7:0 with the upper bits zero.
- R7: A read of 0x6C while the receive FIFO is empty returns 0xDEADBEEF and removes nothing.
- R8: A write to 0x68 while the transmit FIFO holds FIFO_DEPTH bytes is discarded, and evt_tx_overflow is high for the one cycle after that write.
- R9: A returned byte that arrives while the receive FIFO holds FIFO_DEPTH bytes is dropped, and evt_rx_overrun is high for the one cycle after it.
- R10: The words at 0x74 (transmit) and 0x78 (receive) read the FIFO byte count minus one, or 0 when the FIFO is empty.
- R11: cs_n[i] is low exactly when bit i of the slave-select word at 0x70 is 0. It follows a write from the next cycle onward.
- R12: Only one byte is in flight at a time. An offered byte stays valid and unchanged until eng_tx_ready is seen, and no new byte is offered until eng_rx_done has returned the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Byte address of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read |
| eng_tx_valid | output | 1 | A byte is offered to the serial engine |
| eng_tx_ready | input | 1 | The engine accepts the offered byte |
| eng_tx_byte | output | 8 | Byte offered to the engine |
| eng_rx_done | input | 1 | The engine returns the exchanged byte |
| eng_rx_byte | input | 8 | Byte returned by the engine |
| cs_n | output | NUM_CS | Active-low chip selects |
| evt_tx_overflow | output | 1 | Pulse: a transmit write was dropped |
| evt_rx_overrun | output | 1 | Pulse: a returned byte was dropped |

## Verification
The bench builds the block with FIFO_DEPTH set to 16 and NUM_CS set to 3. The shallow FIFOs let a few dozen bus writes and exchanges fill both queues, which reaches the transmit overflow and receive overrun paths quickly. Three chip selects allow independent patterns across several pins. The engine model returns the bitwise inverse of each byte two cycles after the handshake, and its ready line follows an irregular pattern. Together these exercise the hold-until-ready rule, pushes and pops in the same cycle, and a software reset that lands while a byte is in flight.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;

   // register byte addresses
   localparam logic [31:0] A_SWRST = 32'h0000_0040;
   localparam logic [31:0] A_CTRL  = 32'h0000_0060;
   localparam logic [31:0] A_STAT  = 32'h0000_0064;
   localparam logic [31:0] A_TXD   = 32'h0000_0068;
   localparam logic [31:0] A_RXD   = 32'h0000_006C;
   localparam logic [31:0] A_SS    = 32'h0000_0070;
   localparam logic [31:0] A_TXOCC = 32'h0000_0074;
   localparam logic [31:0] A_RXOCC = 32'h0000_0078;

   localparam logic [31:0] SWRST_KEY  = 32'h0000_000A;
   localparam logic [31:0] EMPTY_MARK = 32'hDEAD_BEEF;

   localparam int CB_TXCLR   = 5;
   localparam int CB_RXCLR   = 6;
   localparam int CB_INHIBIT = 8;

   localparam logic [31:0] CTRL_RESET      = 32'h0000_0100;
   localparam logic [31:0] CTRL_SELFCLR    = 32'h0000_0060;

   typedef enum logic {
      SQ_IDLE = 1'b0,
      SQ_WAIT = 1'b1
   } sq_state_e;

endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 256
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clr,
   input  logic                       push,
   input  logic [WIDTH-1:0]           din,
   input  logic                       pop,
   output logic [WIDTH-1:0]           dout,
   output logic [$clog2(DEPTH):0]     count,
   output logic                       full,
   output logic                       empty
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = PTR_W + 1;

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("spi_byte_fifo: DEPTH must be a power of two >= 2");
      end
   endgenerate

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic             do_push, do_pop;

   assign full    = (count == CNT_W'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (clr) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + PTR_W'(1);
         if (do_pop)  rd_ptr <= rd_ptr + PTR_W'(1);
         unique case ({do_push, do_pop})
            2'b10:   count <= count + CNT_W'(1);
            2'b01:   count <= count - CNT_W'(1);
            default: count <= count;
         endcase
      end
   end

endmodule

// File: rtl/spi_xfer_seq.sv
module spi_xfer_seq
   import spi_host_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              inhibit,
   input  logic              tx_empty,
   input  logic [DATA_W-1:0] tx_head,
   output logic              tx_pop,
   input  logic              rx_full,
   output logic              rx_push,
   output logic [DATA_W-1:0] rx_data,
   output logic              eng_tx_valid,
   input  logic              eng_tx_ready,
   output logic [DATA_W-1:0] eng_tx_byte,
   input  logic              eng_rx_done,
   input  logic [DATA_W-1:0] eng_rx_byte,
   output logic              evt_rx_overrun
);
   sq_state_e state_q;

   assign eng_tx_valid = (state_q == SQ_IDLE) && !inhibit && !tx_empty;
   assign eng_tx_byte  = tx_head;
   assign tx_pop       = eng_tx_valid && eng_tx_ready;
   assign rx_push      = (state_q == SQ_WAIT) && eng_rx_done;
   assign rx_data      = eng_rx_byte;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q        <= SQ_IDLE;
         evt_rx_overrun <= 1'b0;
      end else if (clr) begin
         state_q        <= SQ_IDLE;
         evt_rx_overrun <= 1'b0;
      end else begin
         evt_rx_overrun <= rx_push && rx_full;
         unique case (state_q)
            SQ_IDLE: if (tx_pop)  state_q <= SQ_WAIT;
            SQ_WAIT: if (rx_push) state_q <= SQ_IDLE;
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/spi_host_regs.sv
module spi_host_regs
   import spi_host_pkg::*;
#(
   parameter int NUM_CS     = 1,
   parameter int FIFO_DEPTH = 256,
   parameter int ADDR_W     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              eng_tx_valid,
   input  logic              eng_tx_ready,
   output logic [7:0]        eng_tx_byte,
   input  logic              eng_rx_done,
   input  logic [7:0]        eng_rx_byte,
   output logic [NUM_CS-1:0] cs_n,
   output logic              evt_tx_overflow,
   output logic              evt_rx_overrun
);
   localparam int CNT_W = $clog2(FIFO_DEPTH) + 1;

   generate
      if (NUM_CS < 1 || NUM_CS > 32) begin : g_bad_cs
         $error("spi_host_regs: NUM_CS must be 1..32");
      end
      if (ADDR_W < 7 || ADDR_W > 32) begin : g_bad_addr
         $error("spi_host_regs: ADDR_W must be 7..32");
      end
   endgenerate

   logic [31:0] addr_ext;
   logic        wr_en, rd_en;
   logic        soft_clr, ctrl_wr, tx_clr, rx_clr;
   logic [31:0] ctrl_q;
   logic [NUM_CS-1:0] ss_q;
   logic        inhibit;

   logic             tx_push, tx_pop, tx_full, tx_empty;
   logic [7:0]       tx_head;
   logic [CNT_W-1:0] tx_cnt;
   logic             rx_push, rx_pop, rx_full, rx_empty;
   logic [7:0]       rx_din, rx_head;
   logic [CNT_W-1:0] rx_cnt;

   assign addr_ext = 32'(bus_addr);
   assign wr_en    = bus_sel && bus_wr;
   assign rd_en    = bus_sel && !bus_wr;
   assign soft_clr = wr_en && (addr_ext == A_SWRST) && (bus_wdata == SWRST_KEY);
   assign ctrl_wr  = wr_en && (addr_ext == A_CTRL);
   assign tx_clr   = soft_clr || (ctrl_wr && bus_wdata[CB_TXCLR]);
   assign rx_clr   = soft_clr || (ctrl_wr && bus_wdata[CB_RXCLR]);
   assign tx_push  = wr_en && (addr_ext == A_TXD);
   assign rx_pop   = rd_en && (addr_ext == A_RXD);
   assign inhibit  = ctrl_q[CB_INHIBIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q          <= CTRL_RESET;
         ss_q            <= '1;
         evt_tx_overflow <= 1'b0;
      end else if (soft_clr) begin
         ctrl_q          <= CTRL_RESET;
         ss_q            <= '1;
         evt_tx_overflow <= 1'b0;
      end else begin
         evt_tx_overflow <= tx_push && tx_full;
         if (ctrl_wr) ctrl_q <= bus_wdata & ~CTRL_SELFCLR;
         if (wr_en && addr_ext == A_SS) ss_q <= bus_wdata[NUM_CS-1:0];
      end
   end

   spi_byte_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .clr(tx_clr),
      .push(tx_push), .din(bus_wdata[7:0]),
      .pop(tx_pop), .dout(tx_head),
      .count(tx_cnt), .full(tx_full), .empty(tx_empty)
   );

   spi_byte_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .clr(rx_clr),
      .push(rx_push), .din(rx_din),
      .pop(rx_pop), .dout(rx_head),
      .count(rx_cnt), .full(rx_full), .empty(rx_empty)
   );

   spi_xfer_seq #(.DATA_W(8)) u_seq (
      .clk(clk), .rst_n(rst_n), .clr(soft_clr),
      .inhibit(inhibit),
      .tx_empty(tx_empty), .tx_head(tx_head), .tx_pop(tx_pop),
      .rx_full(rx_full), .rx_push(rx_push), .rx_data(rx_din),
      .eng_tx_valid(eng_tx_valid), .eng_tx_ready(eng_tx_ready),
      .eng_tx_byte(eng_tx_byte),
      .eng_rx_done(eng_rx_done), .eng_rx_byte(eng_rx_byte),
      .evt_rx_overrun(evt_rx_overrun)
   );

   genvar gi;
   generate
      for (gi = 0; gi < NUM_CS; gi++) begin : g_cs
         assign cs_n[gi] = ss_q[gi];
      end
   endgenerate

   function automatic logic [31:0] occ(input logic [CNT_W-1:0] c);
      return (c == '0) ? 32'd0 : (32'(c) - 32'd1);
   endfunction

   always_comb begin
      bus_rdata = 32'd0;
      if (rd_en) begin
         unique case (addr_ext)
            A_CTRL:  bus_rdata = ctrl_q;
            A_STAT:  bus_rdata = {28'd0, tx_full, tx_empty, rx_full, rx_empty};
            A_RXD:   bus_rdata = rx_empty ? EMPTY_MARK : 32'(rx_head);
            A_SS:    bus_rdata = 32'(ss_q);
            A_TXOCC: bus_rdata = occ(tx_cnt);
            A_RXOCC: bus_rdata = occ(rx_cnt);
            default: bus_rdata = 32'd0;
         endcase
      end
   end

endmodule

// File: rtl/spi_host_chk.sv
module spi_host_chk
   import spi_host_pkg::*;
#(
   parameter int NUM_CS = 1,
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [NUM_CS-1:0] ss_wdata,
   input logic              inhibit,
   input logic              eng_tx_valid,
   input logic              eng_tx_ready,
   input logic [7:0]        eng_tx_byte,
   input logic [NUM_CS-1:0] cs_n,
   input logic              evt_tx_overflow
);
   logic any_wr, ss_wr, txd_wr;
   assign any_wr = bus_sel && bus_wr;
   assign ss_wr  = any_wr && (32'(bus_addr) == A_SS);
   assign txd_wr = any_wr && (32'(bus_addr) == A_TXD);

   // R5
   inhibit_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inhibit |-> !eng_tx_valid);

   // R12
   offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_tx_valid && !eng_tx_ready && !any_wr) |=> (eng_tx_valid && $stable(eng_tx_byte)));

   // R12
   one_in_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_tx_valid && eng_tx_ready) |=> !eng_tx_valid);

   // R11
   cs_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ss_wr |=> (cs_n == $past(ss_wdata)));

   // R8
   overflow_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_tx_overflow |-> $past(txd_wr));

endmodule

bind spi_host_regs spi_host_chk #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
   .bus_addr(bus_addr), .ss_wdata(bus_wdata[NUM_CS-1:0]),
   .inhibit(inhibit), .eng_tx_valid(eng_tx_valid), .eng_tx_ready(eng_tx_ready),
   .eng_tx_byte(eng_tx_byte), .cs_n(cs_n), .evt_tx_overflow(evt_tx_overflow)
);

// File: tb/sim_spi_host_regs.sv
module sim_spi_host_regs;
   localparam int NUM_CS = 3;
   localparam int DEPTH  = 16;
   localparam int ADDR_W = 8;

   localparam logic [31:0] SWRST = 32'h40, CTRL = 32'h60, STAT = 32'h64, TXD = 32'h68,
                           RXD = 32'h6C, SS = 32'h70, TXOCC = 32'h74, RXOCC = 32'h78;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_sel = 1'b0, bus_wr = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [31:0]       bus_wdata = '0;
   logic [31:0]       bus_rdata;
   logic              eng_tx_valid, eng_tx_ready = 1'b0;
   logic [7:0]        eng_tx_byte;
   logic              eng_rx_done = 1'b0;
   logic [7:0]        eng_rx_byte = '0;
   logic [NUM_CS-1:0] cs_n;
   logic              evt_tx_overflow, evt_rx_overrun;

   always #4 clk = ~clk;

   spi_host_regs #(.NUM_CS(NUM_CS), .FIFO_DEPTH(DEPTH), .ADDR_W(ADDR_W)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .eng_tx_valid(eng_tx_valid), .eng_tx_ready(eng_tx_ready), .eng_tx_byte(eng_tx_byte),
      .eng_rx_done(eng_rx_done), .eng_rx_byte(eng_rx_byte), .cs_n(cs_n),
      .evt_tx_overflow(evt_tx_overflow), .evt_rx_overrun(evt_rx_overrun)
   );

   int checks = 0, fails = 0, cyc = 0, ovf_seen = 0, orun_seen = 0;
   bit done = 0;

   // behavioural reference state
   logic [7:0]        txq[$], rxq[$];
   logic [31:0]       m_ctrl = 32'h100;
   logic [NUM_CS-1:0] m_ss = '1;
   bit                m_busy = 0, m_ovf = 0, m_orun = 0;
   int                eng_delay = 0;
   logic [7:0]        eng_pend = '0;

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   function automatic logic [31:0] exp_rd(input logic [31:0] a);
      int tn = txq.size(), rn = rxq.size();
      case (a)
         CTRL:  return m_ctrl;
         STAT:  return {28'd0, tn == DEPTH, tn == 0, rn == DEPTH, rn == 0};
         RXD:   return (rn == 0) ? 32'hDEADBEEF : 32'(rxq[0]);
         SS:    return 32'(m_ss);
         TXOCC: return (tn == 0) ? 32'd0 : 32'(tn - 1);
         RXOCC: return (rn == 0) ? 32'd0 : 32'(rn - 1);
         default: return 32'd0;
      endcase
   endfunction

   // reference model update at each edge
   always @(posedge clk) begin
      if (!rst_n) begin
         txq.delete(); rxq.delete();
         m_ctrl = 32'h100; m_ss = '1; m_busy = 0; m_ovf = 0; m_orun = 0;
      end else begin
         bit hs, txf, rxf, rxe, n_ovf, n_orun;
         logic [31:0] a;
         a      = 32'(bus_addr);
         hs     = !m_busy && !m_ctrl[8] && txq.size() > 0 && eng_tx_ready;
         txf    = txq.size() == DEPTH;
         rxf    = rxq.size() == DEPTH;
         rxe    = rxq.size() == 0;
         n_ovf  = 0;
         n_orun = 0;
         if (bus_sel && !bus_wr && a == RXD && !rxe) void'(rxq.pop_front());
         if (m_busy && eng_rx_done) begin
            if (rxf) n_orun = 1;
            else rxq.push_back(eng_rx_byte);
            m_busy = 0;
         end
         if (eng_delay > 0) eng_delay--;
         if (hs) begin
            eng_pend  = ~txq[0];
            eng_delay = 2;
            void'(txq.pop_front());
            m_busy = 1;
         end
         if (bus_sel && bus_wr) begin
            case (a)
               SWRST: if (bus_wdata == 32'hA) begin
                  txq.delete(); rxq.delete();
                  m_ctrl = 32'h100; m_ss = '1; m_busy = 0; n_ovf = 0; n_orun = 0;
               end
               CTRL: begin
                  m_ctrl = bus_wdata & ~32'h60;
                  if (bus_wdata[6]) rxq.delete();
                  if (bus_wdata[5]) txq.delete();
               end
               SS:  m_ss = bus_wdata[NUM_CS-1:0];
               TXD: if (txf) n_ovf = 1; else txq.push_back(bus_wdata[7:0]);
               default: ;
            endcase
         end
         m_ovf  = n_ovf;
         m_orun = n_orun;
      end
   end

   // per-cycle comparison and engine stimulus, away from the active edge
   always @(negedge clk) begin
      cyc++;
      if (rst_n && !done) begin
         bit ev;
         ev = !m_busy && !m_ctrl[8] && txq.size() > 0;
         chk("R5 eng_tx_valid", 32'(eng_tx_valid), 32'(ev));
         if (ev && eng_tx_valid) chk("R6 eng_tx_byte", 32'(eng_tx_byte), 32'(txq[0]));
         chk("R11 cs_n", 32'(cs_n), 32'(m_ss));
         chk("R8 evt_tx_overflow", 32'(evt_tx_overflow), 32'(m_ovf));
         chk("R9 evt_rx_overrun", 32'(evt_rx_overrun), 32'(m_orun));
         if (evt_tx_overflow) ovf_seen++;
         if (evt_rx_overrun) orun_seen++;
      end
      eng_tx_ready <= (cyc % 3) != 1;
      eng_rx_done  <= (eng_delay == 1);
      eng_rx_byte  <= eng_pend;
   end

   task automatic wr(input logic [31:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1; bus_wr = 1; bus_addr = a[ADDR_W-1:0]; bus_wdata = d;
      @(posedge clk);
      #1 bus_sel = 0; bus_wr = 0;
   endtask

   task automatic rd(input string tag, input logic [31:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1; bus_wr = 0; bus_addr = a[ADDR_W-1:0];
      #2 d = bus_rdata;
      chk(tag, d, exp_rd(a));
      @(posedge clk);
      #1 bus_sel = 0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1;
      idle(2);

      rd("R1 ctrl", CTRL, d);   chk("R1 ctrl literal", d, 32'h100);
      rd("R1 ss", SS, d);       chk("R1 ss literal", d, 32'h7);
      rd("R1 stat", STAT, d);   chk("R1 stat literal", d, 32'h5);
      rd("R1 txocc", TXOCC, d); chk("R1 txocc literal", d, 32'h0);
      chk("R1 cs_n", 32'(cs_n), 32'h7);

      rd("R7 empty rx", RXD, d); chk("R7 marker", d, 32'hDEADBEEF);
      rd("R7 rxocc", RXOCC, d);  chk("R7 nothing popped", d, 32'h0);

      wr(TXD, 32'h1A5); wr(TXD, 32'hFF3C); wr(TXD, 32'h7);
      idle(10);
      rd("R10 txocc", TXOCC, d); chk("R10 txocc literal", d, 32'h2);
      rd("R5 rxocc held", RXOCC, d); chk("R5 nothing sent", d, 32'h0);

      wr(CTRL, 32'h0);
      idle(30);
      rd("R10 rxocc", RXOCC, d); chk("R10 rxocc literal", d, 32'h2);
      rd("R6 rx0", RXD, d); chk("R6 rx0 literal", d, 32'h5A);
      rd("R6 rx1", RXD, d); chk("R6 rx1 literal", d, 32'hC3);
      rd("R6 rx2", RXD, d); chk("R6 rx2 literal", d, 32'hF8);
      rd("R3 stat", STAT, d); chk("R3 both empty", d, 32'h5);

      wr(CTRL, 32'h100);
      for (int i = 0; i < DEPTH + 1; i++) wr(TXD, 32'(i));
      idle(2);
      chk("R8 overflow seen", 32'(ovf_seen > 0), 32'h1);
      rd("R3 stat txfull", STAT, d); chk("R3 tx full literal", d, 32'h9);
      rd("R10 txocc full", TXOCC, d); chk("R10 full literal", d, 32'(DEPTH - 1));
      wr(STAT, 32'hF);
      rd("R3 stat write ignored", STAT, d); chk("R3 ignored literal", d, 32'h9);

      wr(CTRL, 32'h120);
      rd("R4 stat", STAT, d);   chk("R4 tx flushed", d, 32'h5);
      rd("R4 ctrl", CTRL, d);   chk("R4 selfclear", d, 32'h100);

      wr(CTRL, 32'h0);
      for (int i = 0; i < DEPTH + 3; i++) wr(TXD, 32'(8'h40 + i));
      idle(150);
      chk("R9 overrun seen", 32'(orun_seen > 0), 32'h1);
      rd("R9 stat rxfull", STAT, d); chk("R9 rx full literal", d, 32'h6);
      for (int i = 0; i < 4; i++) rd("R6 drain order", RXD, d);
      wr(CTRL, 32'h140);
      rd("R4 rx flushed", STAT, d); chk("R4 rx flush literal", d, 32'h5);
      rd("R4 ctrl bits", CTRL, d);  chk("R4 ctrl literal", d, 32'h100);

      wr(SS, 32'h6); idle(2); chk("R11 cs 6", 32'(cs_n), 32'h6);
      wr(SS, 32'h3); idle(2); chk("R11 cs 3", 32'(cs_n), 32'h3);
      wr(SS, 32'h2); wr(CTRL, 32'h0);
      wr(SWRST, 32'h5);
      rd("R2 bad key ctrl", CTRL, d); chk("R2 ctrl kept", d, 32'h0);
      rd("R2 bad key ss", SS, d);     chk("R2 ss kept", d, 32'h2);
      wr(SWRST, 32'hA);
      rd("R2 ctrl reset", CTRL, d); chk("R2 ctrl literal", d, 32'h100);
      rd("R2 ss reset", SS, d);     chk("R2 ss literal", d, 32'h7);

      wr(CTRL, 32'h0);
      wr(TXD, 32'h11); wr(TXD, 32'h22); wr(TXD, 32'h33); wr(TXD, 32'h44);
      wr(SWRST, 32'hA);
      idle(10);
      rd("R2 stat after", STAT, d);   chk("R2 empty literal", d, 32'h5);
      rd("R2 rxocc after", RXOCC, d); chk("R2 rxocc literal", d, 32'h0);
      rd("R12 ctrl after", CTRL, d);

      idle(5);
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule